// File: doc/BRIEF.md
# Period Timer with Compare-Driven Restart

This block is a byte-writable up-counter that advances once per increment strobe. It raises a sticky overflow flag when it rolls over from all ones to zero, and it raises an interrupt request when that flag is set and the interrupt is enabled. The count is visible on an output bus, so software or neighbouring logic can read it.

It has several compare channels. Each channel has its own compare value and its own mode field. When a channel's mode selects the restart event, that channel's compare value becomes the counter's period: on the strobe that finds the count equal to the compare value, the counter returns to zero instead of advancing. One channel, the converter channel, also issues a one-cycle start pulse to an external converter when its event fires and the converter-enable input is high. That channel's restart never sets the overflow flag. A restart from any other channel sets the flag, as a period overflow would.

All configuration goes through a single byte write port: a strobe, an address and a data byte. The port has no back-pressure. Every write is accepted in the cycle it is presented, so no ready signal exists. The count and the flags are plain registered status outputs.

Top module: `tmr_evt_timer`

## Requirements
- R1: Each cycle with `tick` high and no count write or restart, the count increases by one. From 0xFFFF it rolls to 0x0000. Reset clears the count, the flag, the interrupt request and the start pulse.
- R2: A rollover from 0xFFFF to 0x0000 sets `irq_flag`. The flag stays set until a write to address 9 with data bit 0 high.
- R3: `irq` is high exactly when `irq_flag` is set and the interrupt-enable bit (address 8, bit 0) is 1.
- R4: When a channel's mode (address 6 for channel 0, address 7 for channel 1) equals 4'b1011, a strobe that finds the count equal to that channel's compare value loads zero. The count therefore cycles through compare+1 values. Channel 0 compare sits at addresses 2 (low byte) and 3 (high byte). Channel 1 compare sits at addresses 4 and 5.
- R5: A channel 1 restart event with `conv_enable` high drives `conv_start` high for the one cycle after the strobe edge. The pulse does not appear when `conv_enable` is low, and a channel 0 event never produces it.
- R6: A channel 1 restart leaves `irq_flag` unchanged. A channel 0 restart sets `irq_flag`.
- R7: A count write in the same cycle as a restart event wins. The written byte is loaded, the other byte is kept, and the restart and the increment are both dropped.
- R8: With the asynchronous-mode bit (address 8, bit 1) set, compare matches neither restart the count nor pulse `conv_start`, and the count keeps advancing on each strobe.
- R9: If a flag-clear write arrives in the same cycle as a flag-setting event, `irq_flag` stays set.
- R10: Address 0 writes count bits 7:0 and address 1 writes count bits 15:8. Each leaves the other byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Increment strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data byte |
| conv_enable | input | 1 | Converter-enable input; allows the start pulse |
| count | output | 16 | Current count value |
| irq_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | One-cycle converter start pulse |

## Verification
The bench uses the default parameters: a 16-bit count, two compare channels, and channel 1 as the converter channel. This gives exactly the address map that the requirements quote. The rollover is reached by preloading the count bytes next to 0xFFFF rather than by stepping through 65536 strobes. A small compare value such as 1 or 2 brings several complete periods within a few cycles. The directed cases place a count write on the same strobe as a channel 1 match, a flag clear on the same strobe as a rollover, and a compare match while the asynchronous mode is set.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int BYTE_W   = 8;
  localparam int MODE_W   = 4;
  localparam logic [MODE_W-1:0] RESTART_MODE = 4'b1011;
endpackage

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 4,
  parameter int CMP_BASE  = 2,
  parameter int MODE_ADDR = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              async_mode,
  output logic              armed_match
);
  localparam int NB = CNT_W / BYTE_W;

  logic [CNT_W-1:0]  cmp_q;
  logic [MODE_W-1:0] mode_q;
  logic [NB-1:0]     byte_we;

  for (genvar b = 0; b < NB; b++) begin : g_we
    assign byte_we[b] = wr_en && (wr_addr == ADDR_W'(CMP_BASE + b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      mode_q <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (byte_we[b]) cmp_q[b*BYTE_W +: BYTE_W] <= wr_data;
      end
      if (wr_en && (wr_addr == ADDR_W'(MODE_ADDR)))
        mode_q <= wr_data[MODE_W-1:0];
    end
  end

  assign armed_match = (mode_q == RESTART_MODE) && !async_mode && (cnt == cmp_q);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic [CNT_W/BYTE_W-1:0]   byte_we,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic                      restart,
  output logic [CNT_W-1:0]          cnt,
  output logic                      cnt_wr,
  output logic                      wrap_evt
);
  localparam int NB = CNT_W / BYTE_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign cnt_wr   = |byte_we;
  assign wrap_evt = tick && !cnt_wr && !restart && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      for (int b = 0; b < NB; b++) begin
        if (byte_we[b]) cnt_q[b*BYTE_W +: BYTE_W] <= wr_data;
      end
    end else if (tick) begin
      cnt_q <= restart ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
    else if (clr_req) flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = flag_q && irq_en;
endmodule

// File: rtl/tmr_evt_timer.sv
module tmr_evt_timer
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_CH  = 2,
  parameter int CONV_CH = 1,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              conv_enable,
  output logic [CNT_W-1:0]  count,
  output logic              irq_flag,
  output logic              irq,
  output logic              conv_start
);
  localparam int NB        = CNT_W / BYTE_W;
  localparam int MODE_BASE = NB * (1 + NUM_CH);
  localparam int CTRL_ADDR = MODE_BASE + NUM_CH;
  localparam int CLR_ADDR  = CTRL_ADDR + 1;
  localparam logic [NUM_CH-1:0] CONV_MASK = NUM_CH'(1) << CONV_CH;

  logic [NB-1:0]     cnt_byte_we;
  logic [NUM_CH-1:0] match;
  logic [NUM_CH-1:0] trig;
  logic              restart;
  logic              cnt_wr;
  logic              wrap_evt;
  logic              ie_q;
  logic              async_q;
  logic              conv_q;
  logic              flag_set;
  logic              flag_clr;

  for (genvar b = 0; b < NB; b++) begin : g_cnt_we
    assign cnt_byte_we[b] = wr_en && (wr_addr == ADDR_W'(b));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_cmp_chan #(
      .CNT_W    (CNT_W),
      .ADDR_W   (ADDR_W),
      .CMP_BASE (NB * (1 + c)),
      .MODE_ADDR(MODE_BASE + c)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .cnt        (count),
      .async_mode (async_q),
      .armed_match(match[c])
    );
    assign trig[c] = tick && match[c];
  end

  assign restart = |trig;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .byte_we (cnt_byte_we),
    .wr_data (wr_data),
    .restart (restart),
    .cnt     (count),
    .cnt_wr  (cnt_wr),
    .wrap_evt(wrap_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      async_q <= 1'b0;
      conv_q  <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR))) begin
        ie_q    <= wr_data[0];
        async_q <= wr_data[1];
      end
      conv_q <= trig[CONV_CH] && conv_enable;
    end
  end

  assign flag_set = !cnt_wr && !trig[CONV_CH] && (wrap_evt || |(trig & ~CONV_MASK));
  assign flag_clr = wr_en && (wr_addr == ADDR_W'(CLR_ADDR)) && wr_data[0];

  tmr_ovf_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(flag_set),
    .clr_req(flag_clr),
    .irq_en (ie_q),
    .flag   (irq_flag),
    .irq    (irq)
  );

  assign conv_start = conv_q;
endmodule

// File: rtl/tmr_evt_timer_chk.sv
module tmr_evt_timer_chk #(
  parameter int CNT_W   = 16,
  parameter int NUM_CH  = 2,
  parameter int CONV_CH = 1,
  parameter int ADDR_W  = 4,
  parameter int CLR_A   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              conv_enable,
  input logic [CNT_W-1:0]  count,
  input logic              irq_flag,
  input logic              irq,
  input logic              conv_start,
  input logic [NUM_CH-1:0] trig,
  input logic              cnt_wr,
  input logic              async_mode
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && trig == '0 && count != CMAX) |=> count == $past(count) + CNT_W'(1));

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && trig == '0 && count == CMAX) |=> (count == '0 && irq_flag));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !(wr_en && wr_addr == ADDR_W'(CLR_A) && wr_data[0])) |=> irq_flag);

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_flag);

  p_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0 && !cnt_wr) |=> count == '0);

  p_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig[CONV_CH] && conv_enable) |=> conv_start);

  p_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig[CONV_CH] && !irq_flag) |=> !irq_flag);

  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0) |=> count[7:0] == $past(wr_data));

  p_async_r8: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode |-> trig == '0);
endmodule

bind tmr_evt_timer tmr_evt_timer_chk #(
  .CNT_W  (CNT_W),
  .NUM_CH (NUM_CH),
  .CONV_CH(CONV_CH),
  .ADDR_W (ADDR_W),
  .CLR_A  (CLR_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .conv_enable(conv_enable),
  .count      (count),
  .irq_flag   (irq_flag),
  .irq        (irq),
  .conv_start (conv_start),
  .trig       (trig),
  .cnt_wr     (cnt_wr),
  .async_mode (async_q)
);

// File: tb/tmr_evt_timer_test.sv
`timescale 1ns/1ps
module tmr_evt_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        conv_enable = 1'b0;
  logic [15:0] count;
  logic        irq_flag, irq, conv_start;

  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  tmr_evt_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .conv_enable(conv_enable), .count(count),
    .irq_flag(irq_flag), .irq(irq), .conv_start(conv_start)
  );

  typedef struct packed {
    logic        w;
    logic        t;
    logic        ce;
    logic [3:0]  a;
    logic [7:0]  d;
    logic [15:0] ecnt;
    logic        eflag;
    logic        eirq;
    logic        econv;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,4'd1,8'hFF,16'hFF00,1'b0,1'b0,1'b0,4'd10}, // R10 high byte
    '{1'b1,1'b0,1'b0,4'd0,8'hFE,16'hFFFE,1'b0,1'b0,1'b0,4'd10}, // R10 low byte
    '{1'b0,1'b1,1'b0,4'd0,8'h00,16'hFFFF,1'b0,1'b0,1'b0,4'd1},  // R1 step
    '{1'b0,1'b1,1'b0,4'd0,8'h00,16'h0000,1'b1,1'b0,1'b0,4'd2},  // R2 rollover sets flag
    '{1'b1,1'b0,1'b0,4'd8,8'h01,16'h0000,1'b1,1'b1,1'b0,4'd3},  // R3 enable
    '{1'b1,1'b0,1'b0,4'd9,8'h01,16'h0000,1'b0,1'b0,1'b0,4'd2},  // R2 clear
    '{1'b1,1'b0,1'b0,4'd8,8'h00,16'h0000,1'b0,1'b0,1'b0,4'd3},
    '{1'b1,1'b0,1'b0,4'd2,8'h02,16'h0000,1'b0,1'b0,1'b0,4'd4},
    '{1'b1,1'b0,1'b0,4'd3,8'h00,16'h0000,1'b0,1'b0,1'b0,4'd4},
    '{1'b1,1'b0,1'b0,4'd6,8'h0B,16'h0000,1'b0,1'b0,1'b0,4'd4},
    '{1'b0,1'b1,1'b0,4'd0,8'h00,16'h0001,1'b0,1'b0,1'b0,4'd4},
    '{1'b0,1'b1,1'b0,4'd0,8'h00,16'h0002,1'b0,1'b0,1'b0,4'd4},
    '{1'b0,1'b1,1'b0,4'd0,8'h00,16'h0000,1'b1,1'b0,1'b0,4'd6},  // R6 ch0 restart sets flag
    '{1'b0,1'b1,1'b0,4'd0,8'h00,16'h0001,1'b1,1'b0,1'b0,4'd4},
    '{1'b1,1'b0,1'b0,4'd9,8'h01,16'h0001,1'b0,1'b0,1'b0,4'd2},
    '{1'b1,1'b0,1'b0,4'd6,8'h00,16'h0001,1'b0,1'b0,1'b0,4'd4},
    '{1'b1,1'b0,1'b0,4'd4,8'h01,16'h0001,1'b0,1'b0,1'b0,4'd4},
    '{1'b1,1'b0,1'b0,4'd5,8'h00,16'h0001,1'b0,1'b0,1'b0,4'd4},
    '{1'b1,1'b0,1'b0,4'd7,8'h0B,16'h0001,1'b0,1'b0,1'b0,4'd4},
    '{1'b0,1'b1,1'b1,4'd0,8'h00,16'h0000,1'b0,1'b0,1'b1,4'd5},  // R5 pulse, R6 no flag
    '{1'b0,1'b1,1'b1,4'd0,8'h00,16'h0001,1'b0,1'b0,1'b0,4'd5},
    '{1'b0,1'b1,1'b0,4'd0,8'h00,16'h0000,1'b0,1'b0,1'b0,4'd5},  // R5 no pulse when disabled
    '{1'b0,1'b1,1'b0,4'd0,8'h00,16'h0001,1'b0,1'b0,1'b0,4'd4}
  };

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic w, input logic t, input logic ce,
                       input logic [3:0] a, input logic [7:0] d);
    wr_en = w; tick = t; conv_enable = ce; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; conv_enable = 1'b0;
  endtask

  task automatic check(input string req, input logic [15:0] ecnt, input logic eflag,
                       input logic eirq, input logic econv);
    applied++;
    if (count !== ecnt || irq_flag !== eflag || irq !== eirq || conv_start !== econv) begin
      errors++;
      $display("FAIL %s: got cnt=%h flag=%b irq=%b conv=%b, want cnt=%h flag=%b irq=%b conv=%b",
               req, count, irq_flag, irq, conv_start, ecnt, eflag, eirq, econv);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    applied++; errors++;
    $display("FAIL watchdog: got timeout, want completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset", 16'h0000, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].w, VECS[i].t, VECS[i].ce, VECS[i].a, VECS[i].d);
      check(tag_name(VECS[i].tag), VECS[i].ecnt, VECS[i].eflag, VECS[i].eirq, VECS[i].econv);
    end

    // R7: count write on the same strobe as a channel 1 match (count 1, compare 1)
    apply(1'b1, 1'b1, 1'b0, 4'd0, 8'h55);
    check("R7", 16'h0055, 1'b0, 1'b0, 1'b0);
    // R10: high-byte write keeps low byte
    apply(1'b1, 1'b0, 1'b0, 4'd1, 8'h12);
    check("R10", 16'h1255, 1'b0, 1'b0, 1'b0);

    // R8: asynchronous mode ignores the match
    apply(1'b1, 1'b0, 1'b0, 4'd8, 8'h02);
    apply(1'b1, 1'b0, 1'b0, 4'd1, 8'h00);
    apply(1'b1, 1'b0, 1'b0, 4'd0, 8'h01);
    check("R8 preload", 16'h0001, 1'b0, 1'b0, 1'b0);
    apply(1'b0, 1'b1, 1'b1, 4'd0, 8'h00);
    check("R8", 16'h0002, 1'b0, 1'b0, 1'b0);
    apply(1'b1, 1'b0, 1'b0, 4'd8, 8'h00);

    // R9: clear on the same cycle as rollover
    apply(1'b1, 1'b0, 1'b0, 4'd1, 8'hFF);
    apply(1'b1, 1'b0, 1'b0, 4'd0, 8'hFF);
    apply(1'b1, 1'b1, 1'b0, 4'd9, 8'h01);
    check("R9", 16'h0000, 1'b1, 1'b0, 1'b0);

    // R3: request follows enable and flag
    apply(1'b1, 1'b0, 1'b0, 4'd8, 8'h01);
    check("R3 on", 16'h0000, 1'b1, 1'b1, 1'b0);
    apply(1'b1, 1'b0, 1'b0, 4'd9, 8'h01);
    check("R3 off", 16'h0000, 1'b0, 1'b0, 1'b0);

    report();
  end
endmodule